// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a serial slave on a two-wire bus. It gives a bus master byte-wide access to a 2048-byte memory. It takes already-synchronized clock and data lines, plus three strap inputs that set its device select and a write-protect input. It drives an enable for an open-drain data driver, so a 1 pulls the data line low. On its memory side it has a plain synchronous port: address, write data and a write strobe go out, and the registered read data comes back.

Each transaction opens with a slave address byte, sent MSB first like every byte on the bus. This byte carries a device-select field, three page bits and a direction bit. The page bits form the top of an 11-bit address latch.

- **Write:** the next byte is the word address, which fills the low eight bits of the latch. Each later byte is written to memory.
- **Read:** no word address is sent. Data starts at the latch value left by earlier traffic, with only the page bits replaced.

The latch steps by one after every data byte in either direction and wraps at the top of memory, so bursts may be of any length. The write-protect input guards only the upper half, where page bit 2 is 1.

Top module: `i2c_mem_slave`

## Requirements
- R1: SDA falling while SCL is high is a start, and it aborts any operation at once; the next byte is read as a slave address. SDA rising while SCL is high is a stop, and it returns the block to idle. A partly received byte is never written.
- R2: Slave address byte layout: bit 7 must be 1, bits 6:4 select the device, bits 3:1 are the page, and bit 0 set to 1 requests a read. The device is addressed when bit 6 equals strap_i[2], bit 5 equals the inverse of strap_i[1], and bit 4 equals strap_i[0].
- R3: On a slave address that does not match, or whose bit 7 is 0, the block gives no acknowledge and keeps SDA released until the next start.
- R4: On a write, the byte after the slave address is the word address. The memory address of the first data byte is {page, word address}.
- R5: On a read, the page field replaces address bits 10:8, and address bits 7:0 keep the value left by the previous transaction.
- R6: The address rises by one after each data byte, read or written, so a burst of any length covers consecutive addresses.
- R7: Stepping from address 0x7FF gives address 0x000.
- R8: The block acknowledges every byte it receives while addressed by pulling SDA low through the ninth SCL clock. It changes sda_oe_o only while SCL is low. After reset SDA is released.
- R9: Each write data byte gives exactly one single-cycle mem_we_o pulse, with mem_addr_o and mem_wdata_o carrying that byte's address and value.
- R10: When wp_i is 1 and page bit 2 (address byte bit 3) is 1, write data is still acknowledged and the address still steps, but mem_we_o stays low. Writes to the lower half and all reads are unaffected.
- R11: On a read, the byte at the current address is driven MSB first. A master acknowledge starts the next byte. A master non-acknowledge releases SDA, and no more data is driven until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (bus level) |
| strap_i | input | 3 | Device-select straps |
| wp_i | input | 1 | Write protect for upper half |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| mem_addr_o | output | 11 | Memory address (address latch) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe, one cycle per byte |
| mem_rdata_i | input | 8 | Registered memory read data |

## Verification
A wrong bit counter or state shows up as a missing or misplaced acknowledge, which the master samples on the ninth clock of the very byte that went wrong. A broken address latch shows first in memory contents or read-back bytes. This appears either one byte later (a wrong step or wrap) or on the next read, which has no word address (lost low bits). Protection and abort faults show as a memory location that changed when it should not have. These are checked at the end of the affected transaction.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = 3;
  localparam int ADDR_W = PAGE_W + BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_e;
endpackage

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges only count as conditions while SCL stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

  p_cond_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o}));
endmodule

// File: rtl/i2cm_addr_latch.sv
module i2cm_addr_latch #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_page_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic                       load_low_i,
  input  logic [ADDR_W-PAGE_W-1:0]   low_i,
  input  logic                       inc_i,
  output logic [ADDR_W-1:0]          addr_o
);
  localparam int LOW_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (inc_i) begin
      addr_q <= addr_q + 1'b1;
    end else begin
      if (load_page_i) addr_q[ADDR_W-1 -: PAGE_W] <= page_i;
      if (load_low_i)  addr_q[LOW_W-1:0]          <= low_i;
    end
  end

  assign addr_o = addr_q;

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && (addr_q == '1)) |=> (addr_q == '0));

  p_low_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_page_i && !load_low_i && !inc_i) |=> (addr_q[LOW_W-1:0] == $past(addr_q[LOW_W-1:0])));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter logic [PAGE_W-1:0] SEL_INV = 3'b010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_rise, scl_fall, start_ev, stop_ev;

  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q, tx_q;
  logic              rw_q, upper_q, oe_q, ack_seen_q, we_q, wr_inc_q;

  logic rx_state, byte_done, dev_hit, load_page, load_low, rd_inc;

  i2cm_cond_det u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_WADR) || (state_q == ST_WR);
  assign byte_done = scl_fall && (cnt_q == CNT_FULL);
  assign dev_hit   = sr_q[7] && (sr_q[6:4] == (strap_i ^ SEL_INV));
  assign load_page = (state_q == ST_DEV) && byte_done && dev_hit;
  assign load_low  = (state_q == ST_WADR) && byte_done;
  assign rd_inc    = (state_q == ST_RD) && scl_fall && (cnt_q == CNT_LAST);

  i2cm_addr_latch #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_page_i (load_page),
    .page_i      (sr_q[3:1]),
    .load_low_i  (load_low),
    .low_i       (sr_q),
    .inc_i       (rd_inc | wr_inc_q),
    .addr_o      (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sr_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      upper_q    <= 1'b0;
      oe_q       <= 1'b0;
      ack_seen_q <= 1'b0;
      we_q       <= 1'b0;
      wr_inc_q   <= 1'b0;
    end else begin
      we_q     <= 1'b0;
      wr_inc_q <= 1'b0;
      if (start_ev) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        if (rx_state && scl_rise && (cnt_q != CNT_FULL)) begin
          sr_q  <= {sr_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end
        unique case (state_q)
          ST_IDLE: ;
          ST_DEV: begin
            if (byte_done) begin
              cnt_q <= '0;
              if (dev_hit) begin
                rw_q    <= sr_q[0];
                upper_q <= sr_q[3];
                oe_q    <= 1'b1;
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_WADR: begin
            if (byte_done) begin
              cnt_q   <= '0;
              oe_q    <= 1'b1;
              state_q <= ST_WADR_ACK;
            end
          end
          ST_WR: begin
            if (byte_done) begin
              cnt_q    <= '0;
              oe_q     <= 1'b1;
              state_q  <= ST_WR_ACK;
              we_q     <= !(wp_i && upper_q);
              wr_inc_q <= 1'b1;
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                tx_q    <= mem_rdata_i;
                oe_q    <= ~mem_rdata_i[BYTE_W-1];
                cnt_q   <= '0;
                state_q <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WADR;
              end
            end
          end
          ST_WADR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt_q == CNT_LAST) begin
                cnt_q   <= '0;
                oe_q    <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~tx_q[BYTE_W-2];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) ack_seen_q <= ~sda_i;
            if (scl_fall) begin
              if (ack_seen_q) begin
                tx_q    <= mem_rdata_i;
                oe_q    <= ~mem_rdata_i[BYTE_W-1];
                cnt_q   <= '0;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = sr_q;

  p_oe_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  p_we_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_start_abort_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev |=> ((state_q == ST_DEV) && (cnt_q == '0)));

  p_idle_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  p_we_in_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (state_q == ST_WR_ACK));
endmodule

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b011;
  localparam logic [2:0] DSEL  = 3'b001;
  localparam logic [18:0] VEC [6] = '{
    {11'h005, 8'h3C}, {11'h1A7, 8'hC3}, {11'h2FF, 8'h00},
    {11'h3E1, 8'hFF}, {11'h480, 8'h5A}, {11'h6D2, 8'h81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe, we;
  logic [10:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [2048];
  logic [7:0] exp_mem [2048];
  wire sda_bus = sda_m & ~sda_oe;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  i2c_mem_slave u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .strap_i     (STRAP),
    .wp_i        (wp),
    .sda_oe_o    (sda_oe),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_we_o    (we),
    .mem_rdata_i (rdata)
  );

  function automatic logic [7:0] seed(input int a);
    logic [10:0] x;
    x = a[10:0];
    return x[7:0] ^ {x[10:8], 5'b10101};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= seed(i);
    end else if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; w(H);
    scl_m = 1'b1; w(H);
    sda_m = 1'b0; w(H);
    scl_m = 1'b0; w(H);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; w(H);
    scl_m = 1'b1; w(H);
    sda_m = 1'b1; w(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(H);
    scl_m = 1'b1; w(H);
    scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; w(H);
    scl_m = 1'b1; w(H / 2);
    ack = sda_bus;
    w(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(H);
      scl_m = 1'b1; w(H / 2);
      b[i] = sda_bus;
      w(H / 2);
      scl_m = 1'b0;
    end
    send_bit(nack);
  endtask

  function automatic logic [7:0] devb(input logic [2:0] pg, input logic rd);
    return {1'b1, DSEL, pg, rd};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < 2048; i++) exp_mem[i] = seed(i);
    w(4);
    chk("R8 reset sda released", sda_oe, 0);
    chk("R9 reset no write", we, 0);
    rst_n = 1'b1;
    w(4);

    // vector walk: write one byte, read it back by setting the address
    for (int v = 0; v < 6; v++) begin
      logic [10:0] a;
      logic [7:0] d;
      a = VEC[v][18:8];
      d = VEC[v][7:0];
      i2c_start;
      wbyte(devb(a[10:8], 1'b0), ack); chk("R2 dev ack", ack, 0);
      wbyte(a[7:0], ack);
      wbyte(d, ack); chk("R8 data ack", ack, 0);
      i2c_stop;
      exp_mem[a] = d;
      chk("R9 mem write", mem[a], d);
      i2c_start;
      wbyte(devb(a[10:8], 1'b0), ack);
      wbyte(a[7:0], ack);
      i2c_start;
      wbyte(devb(a[10:8], 1'b1), ack);
      rbyte(b, 1'b1);
      i2c_stop;
      chk("R4 readback", b, d);
    end

    // address mismatch and bit 7 clear
    i2c_start;
    wbyte({1'b1, 3'b011, 3'b000, 1'b0}, ack); chk("R3 mismatch nack", ack, 1);
    wbyte(8'h10, ack); chk("R3 ignored byte", ack, 1);
    wbyte(8'hEE, ack);
    i2c_stop;
    chk("R3 no write", mem[11'h010], exp_mem[11'h010]);
    i2c_start;
    wbyte({1'b0, DSEL, 3'b000, 1'b0}, ack); chk("R2 bit7 zero nack", ack, 1);
    i2c_stop;

    // burst write across the top of memory
    i2c_start;
    wbyte(devb(3'd7, 1'b0), ack);
    wbyte(8'hFE, ack);
    wbyte(8'h11, ack);
    wbyte(8'h22, ack);
    wbyte(8'h33, ack); chk("R6 burst ack", ack, 0);
    i2c_stop;
    exp_mem[11'h7FE] = 8'h11; exp_mem[11'h7FF] = 8'h22; exp_mem[11'h000] = 8'h33;
    chk("R6 burst second", mem[11'h7FF], 8'h22);
    chk("R7 wrap write", mem[11'h000], 8'h33);

    // read with no word address: latch low bits are 0x01
    i2c_start;
    wbyte(devb(3'd7, 1'b1), ack); chk("R5 read ack", ack, 0);
    rbyte(b, 1'b1);
    i2c_stop;
    chk("R5 low bits kept", b, exp_mem[11'h701]);

    // burst read across the top
    i2c_start;
    wbyte(devb(3'd7, 1'b0), ack);
    wbyte(8'hFF, ack);
    i2c_start;
    wbyte(devb(3'd7, 1'b1), ack);
    rbyte(b, 1'b0); chk("R11 first read", b, 8'h22);
    rbyte(b, 1'b1); chk("R7 wrap read", b, 8'h33);
    rbyte(b, 1'b1); chk("R11 released after nack", b, 8'hFF);
    i2c_stop;

    // write protect upper half
    wp = 1'b1;
    i2c_start;
    wbyte(devb(3'd4, 1'b0), ack);
    wbyte(8'h20, ack);
    wbyte(8'hAA, ack); chk("R10 protected ack", ack, 0);
    wbyte(8'hBB, ack);
    i2c_stop;
    chk("R10 blocked 420", mem[11'h420], exp_mem[11'h420]);
    chk("R10 blocked 421", mem[11'h421], exp_mem[11'h421]);
    i2c_start;
    wbyte(devb(3'd4, 1'b1), ack);
    rbyte(b, 1'b1);
    i2c_stop;
    chk("R10 address stepped", b, exp_mem[11'h422]);
    i2c_start;
    wbyte(devb(3'd1, 1'b0), ack);
    wbyte(8'h30, ack);
    wbyte(8'h5A, ack);
    i2c_stop;
    exp_mem[11'h130] = 8'h5A;
    chk("R10 lower half writes", mem[11'h130], 8'h5A);
    wp = 1'b0;

    // start aborts a partial data byte
    i2c_start;
    wbyte(devb(3'd2, 1'b0), ack);
    wbyte(8'h40, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_start;
    wbyte(devb(3'd2, 1'b1), ack); chk("R1 new op after start", ack, 0);
    rbyte(b, 1'b1);
    i2c_stop;
    chk("R1 start abort no write", mem[11'h240], exp_mem[11'h240]);
    chk("R1 read after abort", b, exp_mem[11'h240]);

    // stop aborts a partial data byte
    i2c_start;
    wbyte(devb(3'd2, 1'b0), ack);
    wbyte(8'h41, ack);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    i2c_stop;
    chk("R1 stop abort no write", mem[11'h241], exp_mem[11'h241]);
    chk("R3 idle released", sda_oe, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule